// File: doc/BRIEF.md
# Sample Rate Converter Input Buffer with Selectable Group Delay

This block is the input sample store of a sample rate converter. Samples arrive with an input strobe at the input rate. An output request takes them out at the output rate. After any re-initialisation the write pointer leads the read pointer by a programmable distance: 16 entries for short delay, or 64 entries for long delay. The positions between the two pointers hold silence. Because of this, the first reads after an initialisation return zero, and the distance sets the group delay of the path. Moving from short to long delay adds 48 input sample periods of latency.

The buffer can hold 128 samples, so the long setting still leaves room for the two rates to drift apart. A read from an empty buffer is an underflow, and a write into a full buffer is an overflow. In either case the block raises a one-cycle flag, sends out zero and re-centres the pointers at the selected distance. A bypass input sends each input sample straight to the output register, with no buffering and no change to the data. While bypass is active the buffer is held in its initial state, so leaving bypass restarts with the selected delay. Interpolation and filtering are done elsewhere.

Top module: `sr_sample_fifo`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid, ovf_flag and unf_flag are 0. The buffer starts with the short distance (16).
- R2: With long_delay=0, after an initialisation and with one write and one read in every cycle, the first 16 reads return zero. Read number 16 (counting from 0) returns the first sample written, and later samples follow in order.
- R3: With long_delay=1 under the same pattern, the first 64 reads return zero and read number 64 returns the first sample written. This is 48 more reads of silence than in R2.
- R4: A change of long_delay re-initialises the buffer in the same cycle. A write in that cycle is discarded. A request in that cycle returns out_valid=1 with out_data=0.
- R5: With bypass=0, out_valid is 1 in exactly the cycle after a cycle with out_req=1. out_data holds its value when out_valid is 0.
- R6: A request while the buffer holds zero samples raises unf_flag for one cycle, returns out_data=0 and re-initialises the buffer to the selected distance.
- R7: A write while the buffer holds 128 samples raises ovf_flag for one cycle, discards the sample and re-initialises the buffer to the selected distance.
- R8: With bypass=1, out_valid and out_data follow in_valid and in_data one cycle later, with the data unchanged. out_req has no effect on the outputs.
- R9: After bypass returns to 0, the buffer starts from the selected distance. With a write and a read in every cycle, 16 zero reads (short delay) come before the first new sample.
- R10: Under uneven write and read patterns that stay between empty and full, the samples come out unchanged and in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Input sample |
| out_req | input | 1 | Output sample request |
| out_data | output | DATA_W | Output sample, registered |
| out_valid | output | 1 | out_data updated in this cycle |
| long_delay | input | 1 | 1 selects the 64-entry distance, 0 selects the 16-entry distance |
| bypass | input | 1 | 1 passes input samples directly to the output |
| ovf_flag | output | 1 | One-cycle overflow indication |
| unf_flag | output | 1 | One-cycle underflow indication |

## Verification
The bench counts the zero reads exactly at both delay settings. A wrong offset, or silence slots left holding stale data, would show up as the first sample arriving one read early or late, or as non-zero data during the silent span.

The bench drains the buffer to one request past empty and fills it to one write past full. A boundary that is off by one would flag early or not at all. A buffer that kept the overflowing sample would then allow a seventeenth read without underflow.

The bypass tests send requests without input strobes. A design that let out_req through in bypass would give spurious valid cycles. A design that did not restart on leaving bypass would output a sample before the 16 silent reads.

A queue-based model checks ordering under uneven rates, which catches pointer or count updates that go wrong when a read and a write happen in the same cycle.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // one-cycle error events raised by the pointer controller
  typedef struct packed {
    logic ovf;
    logic unf;
  } sfifo_evt_t;
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int SHORT_OFS = 16,
  parameter int LONG_OFS  = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_req,
  input  logic          long_delay,
  input  logic          bypass,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic          rd_en,
  output logic          reinit,
  output sfifo_evt_t    evt
);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);
  localparam logic [CW-1:0] SHORT_CNT = CW'(SHORT_OFS);
  localparam logic [CW-1:0] LONG_CNT  = CW'(LONG_OFS);

  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n, ofs;
  logic          sel_q;
  logic          sel_chg;

  always_comb begin
    ofs     = long_delay ? LONG_CNT : SHORT_CNT;
    sel_chg = long_delay ^ sel_q;
    evt.unf = !bypass && out_req  && (cnt_q == '0);
    evt.ovf = !bypass && in_valid && (cnt_q == FULL_CNT);
    reinit  = bypass || sel_chg || evt.unf || evt.ovf;
    wr_en   = in_valid && !reinit;
    rd_en   = out_req  && !reinit;
    wr_n    = wr_q;
    rd_n    = rd_q;
    cnt_n   = cnt_q;
    if (reinit) begin
      wr_n  = ofs[AW-1:0];
      rd_n  = '0;
      cnt_n = ofs;
    end else begin
      if (wr_en) wr_n = wr_q + 1'b1;
      if (rd_en) rd_n = rd_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= SHORT_CNT[AW-1:0];
      rd_q  <= '0;
      cnt_q <= SHORT_CNT;
      sel_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      sel_q <= long_delay;
    end
  end

  assign wr_addr = wr_q;
  assign rd_addr = rd_q;
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld_q, vld_n;

  // data array: no reset, entries are qualified by vld_q
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    vld_n = vld_q;
    if (clr) begin
      vld_n = '0;
    end else begin
      if (wr_en) vld_n[wr_addr] = 1'b1;
      if (rd_en) vld_n[rd_addr] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_n;
  end

  // unwritten slots read as silence
  assign rd_data = vld_q[rd_addr] ? mem[rd_addr] : '0;
endmodule

// File: rtl/sr_sample_fifo.sv
module sr_sample_fifo
  import sfifo_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int DEPTH     = 128,
  parameter int SHORT_OFS = 16,
  parameter int LONG_OFS  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_req,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              long_delay,
  input  logic              bypass,
  output logic              ovf_flag,
  output logic              unf_flag
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]     wr_addr, rd_addr;
  logic              wr_en, rd_en, reinit;
  sfifo_evt_t        evt;
  logic [DATA_W-1:0] rd_data;

  logic [DATA_W-1:0] dat_q, dat_n;
  logic              vld_q, vld_n, ovf_q, unf_q;

  sfifo_ctrl #(
    .DEPTH(DEPTH), .SHORT_OFS(SHORT_OFS), .LONG_OFS(LONG_OFS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_req(out_req),
    .long_delay(long_delay), .bypass(bypass),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .wr_en(wr_en), .rd_en(rd_en),
    .reinit(reinit), .evt(evt)
  );

  sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(reinit),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_comb begin
    vld_n = bypass ? in_valid : out_req;
    dat_n = dat_q;
    if (bypass) begin
      if (in_valid) dat_n = in_data;
    end else if (out_req) begin
      dat_n = rd_en ? rd_data : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      dat_q <= dat_n;
      vld_q <= vld_n;
      ovf_q <= evt.ovf;
      unf_q <= evt.unf;
    end
  end

  assign out_data  = dat_q;
  assign out_valid = vld_q;
  assign ovf_flag  = ovf_q;
  assign unf_flag  = unf_q;
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_req,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              long_delay,
  input logic              bypass,
  input logic              ovf_flag,
  input logic              unf_flag
);
  // R5
  req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && out_req) |=> out_valid);

  // R5
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !out_req) |=> !out_valid);

  // R8
  bypass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && in_valid) |=> (out_valid && out_data == $past(in_data)));

  // R8
  bypass_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !in_valid) |=> !out_valid);

  // R6
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |-> (out_valid && out_data == '0));

  // R6
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |-> $past(out_req && !bypass));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> $past(in_valid && !bypass));

  // R6 R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(unf_flag && ovf_flag));

  // R4
  sel_change_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !bypass && long_delay != $past(long_delay)) |=> (out_data == '0));
endmodule

bind sr_sample_fifo sfifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_req(out_req), .out_data(out_data), .out_valid(out_valid),
  .long_delay(long_delay), .bypass(bypass),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag)
);

// File: tb/tb_sr_sample_fifo.sv
`timescale 1ns/1ps
module tb_sr_sample_fifo;
  localparam int DW = 24;

  logic          clk, rst_n;
  logic          in_valid, out_req, long_delay, bypass;
  logic [DW-1:0] in_data, out_data;
  logic          out_valid, ovf_flag, unf_flag;

  int vectors = 0;
  int fails   = 0;

  sr_sample_fifo dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_req(out_req), .out_data(out_data), .out_valid(out_valid),
    .long_delay(long_delay), .bypass(bypass),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at a falling edge; on return the outputs of that cycle are visible
  task automatic cyc(input logic iv, input logic [DW-1:0] d, input logic rq);
    in_valid = iv;
    in_data  = d;
    out_req  = rq;
    @(negedge clk);
  endtask

  task automatic restart();
    bypass = 1'b1;
    cyc(1'b0, '0, 1'b0);
    bypass = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 ovf_flag",  {31'd0, ovf_flag},  32'd0);
    chk("R1 unf_flag",  {31'd0, unf_flag},  32'd0);
  endtask

  task automatic t_short();
    for (int k = 0; k < 40; k++) begin
      cyc(1'b1, DW'(32'h100000 + k), 1'b1);
      chk("R5 valid", {31'd0, out_valid}, 32'd1);
      chk("R2 data", {8'd0, out_data},
          (k < 16) ? 32'd0 : 32'h100000 + 32'(k - 16));
    end
    cyc(1'b0, '0, 1'b0);
    chk("R5 idle valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_long();
    long_delay = 1'b1;
    cyc(1'b1, 24'hDEAD, 1'b1);
    chk("R4 valid on change", {31'd0, out_valid}, 32'd1);
    chk("R4 zero on change", {8'd0, out_data}, 32'd0);
    for (int k = 0; k < 80; k++) begin
      cyc(1'b1, DW'(32'h200000 + k), 1'b1);
      chk("R3 data", {8'd0, out_data},
          (k < 64) ? 32'd0 : 32'h200000 + 32'(k - 64));
    end
    long_delay = 1'b0;
    cyc(1'b0, '0, 1'b0);
    chk("R4 no flag", {30'd0, ovf_flag, unf_flag}, 32'd0);
  endtask

  task automatic t_underflow();
    for (int k = 0; k < 16; k++) begin
      cyc(1'b0, '0, 1'b1);
      chk("R6 silence", {8'd0, out_data}, 32'd0);
      chk("R6 no early flag", {31'd0, unf_flag}, 32'd0);
    end
    cyc(1'b0, '0, 1'b1);
    chk("R6 flag", {31'd0, unf_flag}, 32'd1);
    chk("R6 zero", {8'd0, out_data}, 32'd0);
    cyc(1'b1, 24'h000055, 1'b0);
    chk("R6 pulse", {31'd0, unf_flag}, 32'd0);
    for (int k = 0; k < 16; k++) begin
      cyc(1'b0, '0, 1'b1);
      chk("R6 recentred", {8'd0, out_data}, 32'd0);
    end
    cyc(1'b0, '0, 1'b1);
    chk("R6 sample after recentre", {8'd0, out_data}, 32'h55);
  endtask

  task automatic t_overflow();
    restart();
    for (int k = 0; k < 112; k++) begin
      cyc(1'b1, DW'(k), 1'b0);
      if (k == 111) chk("R7 no early flag", {31'd0, ovf_flag}, 32'd0);
    end
    cyc(1'b1, 24'h000077, 1'b0);
    chk("R7 flag", {31'd0, ovf_flag}, 32'd1);
    cyc(1'b0, '0, 1'b0);
    chk("R7 pulse", {31'd0, ovf_flag}, 32'd0);
    for (int k = 0; k < 16; k++) begin
      cyc(1'b0, '0, 1'b1);
      chk("R7 recentred silence", {8'd0, out_data}, 32'd0);
    end
    cyc(1'b0, '0, 1'b1);
    chk("R7 sample discarded", {31'd0, unf_flag}, 32'd1);
  endtask

  task automatic t_bypass();
    bypass = 1'b1;
    cyc(1'b1, 24'h0ABCDE, 1'b1);
    chk("R8 valid", {31'd0, out_valid}, 32'd1);
    chk("R8 data", {8'd0, out_data}, 32'h0ABCDE);
    cyc(1'b0, '0, 1'b1);
    chk("R8 req ignored", {31'd0, out_valid}, 32'd0);
    chk("R8 data held", {8'd0, out_data}, 32'h0ABCDE);
    cyc(1'b1, 24'h012345, 1'b0);
    chk("R8 valid without req", {31'd0, out_valid}, 32'd1);
    chk("R8 data 2", {8'd0, out_data}, 32'h012345);
    bypass = 1'b0;
    for (int k = 0; k < 20; k++) begin
      cyc(1'b1, DW'(32'h300000 + k), 1'b1);
      chk("R9 data", {8'd0, out_data},
          (k < 16) ? 32'd0 : 32'h300000 + 32'(k - 16));
    end
  endtask

  task automatic t_burst();
    logic [DW-1:0] q[$];
    restart();
    for (int k = 0; k < 16; k++) q.push_back('0);
    for (int k = 0; k < 200; k++) begin
      logic iv, rq;
      logic [DW-1:0] exp;
      iv = (k % 3) != 2;
      rq = (k % 2) == 0;
      exp = rq ? q.pop_front() : '0;
      if (iv) q.push_back(DW'(32'h400000 + k));
      cyc(iv, DW'(32'h400000 + k), rq);
      if (rq) chk("R10 order", {8'd0, out_data}, {8'd0, exp});
    end
    while (q.size() > 0) begin
      logic [DW-1:0] exp;
      exp = q.pop_front();
      cyc(1'b0, '0, 1'b1);
      chk("R10 drain", {8'd0, out_data}, {8'd0, exp});
    end
    chk("R10 no flags", {30'd0, ovf_flag, unf_flag}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; out_req = 1'b0;
    long_delay = 1'b0; bypass = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc(1'b0, '0, 1'b0);
    t_reset();
    t_short();
    t_long();
    t_underflow();
    t_overflow();
    t_bypass();
    t_burst();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule